// File: doc/BRIEF.md
# Multi-mode 16-bit timer counter with tick prescaler

This block is a timer core for one clock domain. Four tick-enable inputs stand in for four possible timing sources. A 2-bit source field picks one of them. A prescaler then passes every 1st, 2nd, 4th or 8th selected tick on as a counter advance.

The 16-bit counter can run in four modes: halted, counting up to a period value, free-running through the full 16-bit range, or sweeping up to the period value and back down to zero. The period value is the compare register 0 input. Any wrap, or a return to zero during a downward sweep, sets a sticky interrupt flag. An enable bit gates that flag onto the interrupt request. A one-cycle strobe marks each arrival of the count at the period value.

Software programs a single 9-bit control word through a write strobe. A read-back of the word is always available. The clear bit in the word acts only in the cycle it is written.

Top module: `mm_timer`

## Requirements
- R1: Control bits [8:7] select which `src_tick` bit drives the prescaler: code s uses `src_tick[s]`. Ticks on the other inputs have no effect on the count.
- R2: Control bits [6:5] hold a divider code d. The count advances once for every 2^d selected ticks, counted from the last clear.
- R3: With mode bits [4:3] = 00, the count holds its value whatever the tick inputs do.
- R4: With mode 01 the count runs 0,1,…,P and returns to 0 on the next advance, where P is `period`. That return sets the flag.
- R5: With mode 10 the count runs past P up to 0xFFFF and returns to 0 on the next advance. That return sets the flag.
- R6: With mode 11 the count rises to P and falls back to 0, one step per advance, and repeats. The flag is set in the cycle the count reaches 0 on the way down.
- R7: Writing the control word with bit 2 set makes the count 0 after that clock edge, even when an advance falls in the same cycle. The same write resets the prescaler phase and makes the next sweep step upward. Bit 2 always reads back as 0.
- R8: `irq` is high exactly when the flag (bit 0) and the interrupt enable (bit 1) are both set.
- R9: The flag stays set until a control write with bit 0 = 0. A write with bit 0 = 1 sets it. A flag-setting event in the same cycle as a clearing write leaves it set.
- R10: `equ0` is high for exactly one clock cycle, the first cycle in which the count has moved onto P.
- R11: After reset the count, the control word, `equ0` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_tick | input | NSRC (4) | Tick enables of the four timing sources |
| period | input | CNT_W (16) | Compare register 0: the period value P |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 9 | Control word to write |
| ctl_rdata | output | 9 | Control word read-back, clear bit always 0 |
| count | output | CNT_W (16) | Current count |
| equ0 | output | 1 | One-cycle strobe when the count moves onto P |
| irq | output | 1 | Timer interrupt request |

## Verification
The assertions assume that `period` stays the same across the cycles they compare. They also assume that `ctl_we` is a single-cycle strobe and that every tick input is already synchronous to `clk`. The stimulus changes `period` only while the counter is halted, or just before a write that clears the count. It drives all inputs on the falling edge and raises the write strobe for exactly one cycle per write. Tick inputs are held high or low for whole test phases, so the exact cycle of every advance is known.

// File: rtl/mm_timer_pkg.sv
package mm_timer_pkg;

  typedef enum logic [1:0] {
    MODE_HALT = 2'b00,
    MODE_UP   = 2'b01,
    MODE_FREE = 2'b10,
    MODE_UPDN = 2'b11
  } run_mode_e;

  // Control word, bit 0 at the bottom.
  typedef struct packed {
    logic [1:0] src;   // [8:7]
    logic [1:0] div;   // [6:5]
    run_mode_e  mode;  // [4:3]
    logic       clr;   // [2] acts on write only
    logic       ie;    // [1]
    logic       flag;  // [0]
  } ctl_word_t;

  localparam int CTL_W = $bits(ctl_word_t);
  localparam int SEL_W = 2;
  localparam int DIV_W = 2;

endpackage

// File: rtl/mm_timer_rst_sync.sv
module mm_timer_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/mm_timer_presc.sv
module mm_timer_presc #(
  parameter int NSRC  = 4,
  parameter int SEL_W = 2,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic             clr,
  output logic             adv
);
  localparam int PS_W = (1 << DIV_W) - 1;

  logic            sel_tick;
  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] ps_d;
  logic [PS_W-1:0] mask;

  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SEL_W'(i)) sel_tick = src_tick[i];
    end
  end

  // Low d bits of the phase counter all ones marks every 2^d-th tick.
  assign mask = ~({PS_W{1'b1}} << div);
  assign adv  = sel_tick && ((ps_q & mask) == mask);

  always_comb begin
    ps_d = ps_q;
    if (clr)           ps_d = '0;
    else if (sel_tick) ps_d = ps_q + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_q <= '0;
    else        ps_q <= ps_d;
  end
endmodule

// File: rtl/mm_timer_core.sv
module mm_timer_core
  import mm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  input  run_mode_e        mode,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             equ0,
  output logic             evt
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic             equ_q, equ_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    evt   = 1'b0;
    if (clr) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (adv) begin
      unique case (mode)
        MODE_UP: begin
          if (cnt_q >= period) begin
            cnt_d = '0;
            evt   = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        MODE_FREE: begin
          if (cnt_q == MAXV) begin
            cnt_d = '0;
            evt   = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        MODE_UPDN: begin
          if (up_q && (cnt_q < period)) begin
            cnt_d = cnt_q + ONE;
          end else if (cnt_q == '0) begin
            up_d = 1'b1;                 // floor reached, climb again
          end else begin
            cnt_d = cnt_q - ONE;
            up_d  = 1'b0;
            if (cnt_q == ONE) begin
              evt  = 1'b1;
              up_d = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign equ_d = !clr && (cnt_d == period) && (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      equ_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      equ_q <= equ_d;
    end
  end

  assign count = cnt_q;
  assign equ0  = equ_q;
endmodule

// File: rtl/mm_timer_ctl.sv
module mm_timer_ctl
  import mm_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  ctl_word_t wr_word,
  input  logic      flag_set,
  output ctl_word_t cur,
  output logic      clr_now
);
  ctl_word_t cur_q, cur_d;

  always_comb begin
    cur_d = cur_q;
    if (wr_en) begin
      cur_d.src  = wr_word.src;
      cur_d.div  = wr_word.div;
      cur_d.mode = wr_word.mode;
      cur_d.ie   = wr_word.ie;
      cur_d.flag = wr_word.flag;
    end
    if (flag_set) cur_d.flag = 1'b1;   // event wins over a clearing write
    cur_d.clr = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end

  assign cur     = cur_q;
  assign clr_now = wr_en && wr_word.clr;
endmodule

// File: rtl/mm_timer.sv
module mm_timer
  import mm_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NSRC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [CNT_W-1:0] period,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic [CNT_W-1:0] count,
  output logic             equ0,
  output logic             irq
);
  logic      rst_sync_n;
  ctl_word_t cur;
  logic      clr_now;
  logic      adv;
  logic      evt;

  mm_timer_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  mm_timer_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (ctl_we),
    .wr_word  (ctl_word_t'(ctl_wdata)),
    .flag_set (evt),
    .cur      (cur),
    .clr_now  (clr_now)
  );

  mm_timer_presc #(.NSRC(NSRC), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .src_tick (src_tick),
    .sel      (cur.src),
    .div      (cur.div),
    .clr      (clr_now),
    .adv      (adv)
  );

  mm_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .adv    (adv),
    .clr    (clr_now),
    .mode   (cur.mode),
    .period (period),
    .count  (count),
    .equ0   (equ0),
    .evt    (evt)
  );

  assign ctl_rdata = cur;
  assign irq       = cur.flag && cur.ie;
endmodule

// File: rtl/mm_timer_chk.sv
module mm_timer_chk #(
  parameter int CNT_W = 16,
  parameter int CTL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] period,
  input logic             equ0
);
  assert_stop_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[4:3] == 2'b00 && !ctl_we) |=> $stable(count));

  assert_up_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[4:3] == 2'b01 && !ctl_we && count == period)
      |=> (count == $past(period) || count == '0));

  assert_sweep_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[4:3] == 2'b11 && !ctl_we)
      |=> (count == $past(count) || count == $past(count) + 1'b1
           || count == $past(count) - 1'b1));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[2]) |=> (count == '0));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[0] && !ctl_we) |=> ctl_rdata[0]);

  assert_equ0_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    equ0 |-> (count == period));

  assert_equ0_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    equ0 |=> (!equ0 || period != $past(period)));
endmodule

bind mm_timer mm_timer_chk #(.CNT_W(CNT_W), .CTL_W(CTL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .ctl_rdata (ctl_rdata),
  .count     (count),
  .period    (period),
  .equ0      (equ0)
);

// File: tb/mm_timer_bench.sv
module mm_timer_bench;
  localparam int CLK_P = 10;
  localparam int CNT_W = 16;
  localparam int NSRC  = 4;
  localparam int CW    = 9;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NSRC-1:0]  src_tick;
  logic [CNT_W-1:0] period;
  logic             ctl_we;
  logic [CW-1:0]    ctl_wdata;
  logic [CW-1:0]    ctl_rdata;
  logic [CNT_W-1:0] count;
  logic             equ0;
  logic             irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mm_timer #(.CNT_W(CNT_W), .NSRC(NSRC)) u_mm_timer (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .period(period),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .count(count), .equ0(equ0), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] cw(input int src, input int div, input int mode,
                                      input bit clr, input bit ie, input bit flag);
    return {src[1:0], div[1:0], mode[1:0], clr, ie, flag};
  endfunction

  task automatic wr(input logic [CW-1:0] w);
    ctl_we    = 1'b1;
    ctl_wdata = w;
    @(negedge clk);
    ctl_we    = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11", "count", count, 0);
    chk("R11", "ctl_rdata", ctl_rdata, 0);
    chk("R11", "equ0", equ0, 0);
    chk("R11", "irq", irq, 0);
  endtask

  task automatic t_up;
    period = 5;
    wr(cw(0, 0, 1, 1, 1, 0));
    chk("R7", "count after clear", count, 0);
    for (int k = 1; k <= 5; k++) begin
      step(1);
      chk("R4", "up count", count, k);
      chk("R9", "flag before wrap", ctl_rdata[0], 0);
    end
    chk("R10", "equ0 at period", equ0, 1);
    step(1);
    chk("R4", "wrap to 0", count, 0);
    chk("R10", "equ0 one cycle", equ0, 0);
    chk("R4", "flag on wrap", ctl_rdata[0], 1);
    chk("R8", "irq with ie", irq, 1);
    chk("R7", "clear bit reads 0", ctl_rdata[2], 0);
    wr(cw(0, 0, 1, 0, 1, 0));
    chk("R9", "flag cleared by write", ctl_rdata[0], 0);
    chk("R8", "irq after flag clear", irq, 0);
    step(4);
    chk("R4", "count before wrap", count, 5);
    wr(cw(0, 0, 1, 0, 1, 0));
    chk("R4", "wrap during write", count, 0);
    chk("R9", "event beats clear", ctl_rdata[0], 1);
    wr(cw(0, 0, 1, 0, 0, 1));
    chk("R9", "software set", ctl_rdata[0], 1);
    chk("R8", "irq gated off", irq, 0);
    wr(cw(0, 0, 1, 0, 1, 1));
    chk("R8", "irq gated on", irq, 1);
  endtask

  task automatic t_stop;
    logic [CNT_W-1:0] held;
    wr(cw(0, 0, 0, 0, 0, 0));
    held = count;
    chk("R3", "held value nonzero", held, 3);
    step(10);
    chk("R3", "count held in halt", count, held);
    wr(cw(0, 0, 0, 1, 0, 0));
    chk("R7", "clear while halted", count, 0);
  endtask

  task automatic t_div;
    period = 100;
    for (int d = 0; d < 4; d++) begin
      int n;
      n = 1 << d;
      wr(cw(0, d, 1, 1, 0, 0));
      if (n > 1) begin
        step(n - 1);
        chk("R2", "no advance yet", count, 0);
      end
      step(1);
      chk("R2", "first advance", count, 1);
      step(n);
      chk("R2", "second advance", count, 2);
    end
    wr(cw(0, 3, 1, 1, 0, 0));
    step(5);
    wr(cw(0, 3, 1, 1, 0, 0));
    step(7);
    chk("R7", "prescaler phase reset", count, 0);
    step(1);
    chk("R7", "advance after 8 ticks", count, 1);
  endtask

  task automatic t_src;
    period = 100;
    for (int s = 0; s < NSRC; s++) begin
      src_tick = NSRC'(1) << s;
      wr(cw(s, 0, 1, 1, 0, 0));
      step(3);
      chk("R1", "selected source counts", count, 3);
      src_tick = ~(NSRC'(1) << s);
      wr(cw(s, 0, 1, 1, 0, 0));
      step(3);
      chk("R1", "other sources ignored", count, 0);
    end
    src_tick = '1;
  endtask

  task automatic t_updown;
    period = 3;
    wr(cw(0, 0, 3, 1, 0, 0));
    for (int k = 1; k <= 12; k++) begin
      int m;
      int e;
      step(1);
      m = k % 6;
      e = (m <= 3) ? m : 6 - m;
      chk("R6", "sweep count", count, e);
      if (k == 3) chk("R10", "equ0 at top", equ0, 1);
      if (k == 4) chk("R10", "equ0 dropped", equ0, 0);
      if (k == 5) chk("R6", "flag before floor", ctl_rdata[0], 0);
      if (k == 6) chk("R6", "flag at floor", ctl_rdata[0], 1);
    end
    step(4);
    chk("R6", "falling at 2", count, 2);
    wr(cw(0, 0, 3, 1, 0, 0));
    chk("R7", "clear in sweep", count, 0);
    step(1);
    chk("R7", "direction reset upward", count, 1);
  endtask

  task automatic t_free;
    period = 5;
    wr(cw(0, 0, 2, 1, 0, 0));
    step(6);
    chk("R5", "passes period", count, 6);
    step(65529);
    chk("R5", "top of range", count, 65535);
    chk("R5", "flag before wrap", ctl_rdata[0], 0);
    step(1);
    chk("R5", "wrap to 0", count, 0);
    chk("R5", "flag on wrap", ctl_rdata[0], 1);
  endtask

  initial begin
    rst_n     = 1'b0;
    src_tick  = '1;
    period    = '0;
    ctl_we    = 1'b0;
    ctl_wdata = '0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_up();
    t_stop();
    t_div();
    t_src();
    t_updown();
    t_free();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule